// File: doc/BRIEF.md
# Audio Serial Master Clock Generator

This block produces the frame clock and the bit clock of an audio serial port from the master clock when the port is the clock master. A ratio code sets how many master-clock cycles make one frame. A bits-per-frame select sets how many bit-clock periods fall inside that frame. Non-power-of-two ratios (192, 384, 768, 1152) are divided exactly. The bit clock is built at half-master-clock resolution, so periods of an odd number of half cycles are possible.

When the mode input selects slave, the block drives nothing: the output enable drops, both clocks are held low and the dividers stay in reset. The configuration is sampled only at frame boundaries, so a setting written mid-frame never tears a frame. An unused ratio code stops both clocks and raises an error flag.

The block has no data path, so there is no valid/ready interface. All pins are plain control or clock signals.

Top module: `aclk_master_gen`

## Requirements
- R1: While `master_en` is 0, `bclk`, `lrclk` and `clk_oe` are low from the next `mclk` rising edge on. Reset gives the same state. While `master_en` is 1, `clk_oe` is high from the next rising edge on.
- R2: `ratio_code` sets the frame length R in `mclk` cycles: 0→128, 1→192, 2→256, 3→384, 4→512, 5→768, 6→1152. The first frame starts with the first `mclk` cycle after the rising edge that sees a legal code in master mode.
- R3: `lrclk` is low for the first R/2 `mclk` cycles of a frame and high for the last R/2.
- R4: `bpf_sel` sets the bit-clock periods per frame N: 0→64, 1→32, 2→256, 3→64 (same as 0).
- R5: With `bpf_sel`=2 and a ratio of 128 or 192, N is forced to 128.
- R6: A bit-clock period lasts Q = 2R/N half `mclk` cycles. The first half of an `mclk` cycle is its high phase. Each period starts low and is high for its last floor(Q/2) halves.
- R7: With `bpf_sel` of 0 or 3 and a ratio of 192 or 1152, `bclk` is high for the last Q/3 halves of each period.
- R8: `lrclk` changes only at a falling edge of `bclk`.
- R9: A change of `ratio_code` or `bpf_sel` during a frame takes effect at the next frame boundary.
- R10: `ratio_code`=7 in master mode raises `cfg_err` at once, combinationally. It holds `bclk` and `lrclk` low from the next rising edge while `clk_oe` stays high. When a legal code returns, a fresh frame starts as in R2. In slave mode `cfg_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1 = generate clocks (master), 0 = slave |
| ratio_code | input | 3 | Master-clock cycles per frame selector |
| bpf_sel | input | 2 | Bit-clock periods per frame selector |
| lrclk | output | 1 | Generated frame clock |
| bclk | output | 1 | Generated bit clock |
| clk_oe | output | 1 | Output enable for the two clocks |
| cfg_err | output | 1 | Illegal ratio code in master mode |

## Verification
A configuration change can arrive in the final cycle of a frame, in the same cycle as the frame reload. It can also arrive many cycles before the boundary, so the reload must wait for it. The bench writes new codes at chosen frame positions, including the last one. It then compares every half cycle of the following frames against a waveform computed from the old settings up to the boundary and from the new settings after it. The error code is also applied partway through a running frame, and the bench checks that the clocks stop on the next edge and restart at frame position zero.

// File: rtl/acg_pkg.sv
package acg_pkg;
  localparam int unsigned ACG_MAX_RATIO = 1152;
  localparam int unsigned ACG_MIN_BPF   = 32;
  localparam int unsigned K_W = $clog2(ACG_MAX_RATIO);
  localparam int unsigned Q_W = $clog2(2 * ACG_MAX_RATIO / ACG_MIN_BPF + 1);

  typedef struct packed {
    logic [K_W-1:0] ratio;  // mclk cycles per frame
    logic [Q_W-1:0] per;    // half-mclk units per bclk period
    logic [Q_W-1:0] hi;     // half units high at the end of a period
  } acg_cfg_t;

  function automatic logic [K_W-1:0] acg_ratio(input logic [2:0] code);
    case (code)
      3'd0:    return K_W'(128);
      3'd1:    return K_W'(192);
      3'd3:    return K_W'(384);
      3'd4:    return K_W'(512);
      3'd5:    return K_W'(768);
      3'd6:    return K_W'(1152);
      default: return K_W'(256);
    endcase
  endfunction

  // log2 of bclk periods per frame
  function automatic int unsigned acg_bpf_shift(input logic [2:0] code,
                                                input logic [1:0] sel);
    case (sel)
      2'b01:   return 5;
      2'b10:   return (code <= 3'd1) ? 7 : 8;
      default: return 6;
    endcase
  endfunction

  function automatic acg_cfg_t acg_decode(input logic [2:0] code,
                                          input logic [1:0] sel);
    acg_cfg_t c;
    logic third;
    c.ratio = acg_ratio(code);
    c.per   = Q_W'((32'(c.ratio) << 1) >> acg_bpf_shift(code, sel));
    third   = (sel[1] == sel[0]) && ((code == 3'd1) || (code == 3'd6));
    c.hi    = third ? Q_W'(32'(c.per) / 3) : (c.per >> 1);
    return c;
  endfunction
endpackage

// File: rtl/acg_cfg_decode.sv
module acg_cfg_decode
  import acg_pkg::*;
(
  input  logic [2:0] code,
  input  logic [1:0] sel,
  output acg_cfg_t   cfg
);
  always_comb cfg = acg_decode(code, sel);
endmodule

// File: rtl/acg_frame_seq.sv
module acg_frame_seq
  import acg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  acg_cfg_t       cfg_in,
  output logic [K_W-1:0] k_nxt,
  output logic [Q_W-1:0] q_nxt,
  output acg_cfg_t       cfg_nxt
);
  logic           active_q, act_nxt;
  logic [K_W-1:0] k_q;
  logic [Q_W-1:0] q_q;
  acg_cfg_t       cfg_q;
  logic           last;
  logic [Q_W:0]   q_step;

  assign last   = (k_q == cfg_q.ratio - K_W'(1));
  assign q_step = {1'b0, q_q} + (Q_W+1)'(2);

  always_comb begin
    k_nxt   = k_q;
    q_nxt   = q_q;
    cfg_nxt = cfg_q;
    act_nxt = active_q;
    if (!run) begin
      k_nxt   = '0;
      q_nxt   = '0;
      act_nxt = 1'b0;
    end else if (!active_q || last) begin
      k_nxt   = '0;
      q_nxt   = '0;
      cfg_nxt = cfg_in;
      act_nxt = 1'b1;
    end else begin
      k_nxt = k_q + K_W'(1);
      q_nxt = (q_step >= {1'b0, cfg_q.per}) ? Q_W'(q_step - {1'b0, cfg_q.per})
                                            : Q_W'(q_step);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      k_q      <= '0;
      q_q      <= '0;
      cfg_q    <= acg_decode(3'b010, 2'b00);
    end else begin
      active_q <= act_nxt;
      k_q      <= k_nxt;
      q_q      <= q_nxt;
      cfg_q    <= cfg_nxt;
    end
  end

  // R9: the latched configuration only moves on a frame start
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (k_q != '0) |-> $stable(cfg_q));
  // R2: the frame position never leaves the frame
  p_k_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (k_q < cfg_q.ratio));
  // R6: the half-unit phase stays inside one bclk period
  p_q_in_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (q_q < cfg_q.per));
endmodule

// File: rtl/acg_wave.sv
module acg_wave
  import acg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [K_W-1:0] k_nxt,
  input  logic [Q_W-1:0] q_nxt,
  input  acg_cfg_t       cfg_nxt,
  output logic           ph_a,
  output logic           ph_b,
  output logic           lr
);
  logic [Q_W-1:0] q_b, thr;
  logic           run_q;

  assign thr = cfg_nxt.per - cfg_nxt.hi;
  assign q_b = (q_nxt + Q_W'(1) == cfg_nxt.per) ? '0 : q_nxt + Q_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_a  <= 1'b0;
      ph_b  <= 1'b0;
      lr    <= 1'b0;
      run_q <= 1'b0;
    end else begin
      ph_a  <= run && (q_nxt >= thr);
      ph_b  <= run && (q_b >= thr);
      lr    <= run && (k_nxt >= (cfg_nxt.ratio >> 1));
      run_q <= run;
    end
  end

  // R8: frame clock moves only where the bit clock falls
  p_lr_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && (lr != $past(lr))) |-> (!ph_a && $past(ph_b)));
endmodule

// File: rtl/aclk_master_gen.sv
module aclk_master_gen
  import acg_pkg::*;
(
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       master_en,
  input  logic [2:0] ratio_code,
  input  logic [1:0] bpf_sel,
  output logic       lrclk,
  output logic       bclk,
  output logic       clk_oe,
  output logic       cfg_err
);
  logic           run;
  logic           ph_a, ph_b, lr_r;
  acg_cfg_t       cfg_in, cfg_nxt;
  logic [K_W-1:0] k_nxt;
  logic [Q_W-1:0] q_nxt;

  assign run     = master_en && (ratio_code != 3'b111);
  assign cfg_err = master_en && (ratio_code == 3'b111);

  acg_cfg_decode u_dec (.code(ratio_code), .sel(bpf_sel), .cfg(cfg_in));

  acg_frame_seq u_seq (
    .clk(mclk), .rst_n(rst_n), .run(run), .cfg_in(cfg_in),
    .k_nxt(k_nxt), .q_nxt(q_nxt), .cfg_nxt(cfg_nxt)
  );

  acg_wave u_wave (
    .clk(mclk), .rst_n(rst_n), .run(run), .k_nxt(k_nxt), .q_nxt(q_nxt),
    .cfg_nxt(cfg_nxt), .ph_a(ph_a), .ph_b(ph_b), .lr(lr_r)
  );

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) clk_oe <= 1'b0;
    else        clk_oe <= master_en;
  end

  // first half of each mclk cycle is its high phase
  assign bclk  = mclk ? ph_a : ph_b;
  assign lrclk = lr_r;

  // R1: slave mode quiets everything on the next edge
  p_slave_quiet_r1: assert property (@(posedge mclk) disable iff (!rst_n)
    !master_en |=> (!clk_oe && !ph_a && !ph_b && !lr_r));
  // R10: illegal code stops clocks but keeps the enable
  p_err_stop_r10: assert property (@(posedge mclk) disable iff (!rst_n)
    (master_en && ratio_code == 3'b111) |=> (clk_oe && !ph_a && !ph_b && !lr_r));
endmodule

// File: tb/sim_aclk_master_gen.sv
`timescale 1ns/1ps
module sim_aclk_master_gen;
  logic mclk = 1'b0;
  logic rst_n = 1'b0;
  logic master_en = 1'b0;
  logic [2:0] ratio_code = 3'd2;
  logic [1:0] bpf_sel = 2'd0;
  logic lrclk, bclk, clk_oe, cfg_err;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 mclk = ~mclk;

  aclk_master_gen u0 (
    .mclk(mclk), .rst_n(rst_n), .master_en(master_en), .ratio_code(ratio_code),
    .bpf_sel(bpf_sel), .lrclk(lrclk), .bclk(bclk), .clk_oe(clk_oe), .cfg_err(cfg_err)
  );

  function automatic int f_ratio(input int c);
    case (c)
      0: return 128; 1: return 192; 2: return 256; 3: return 384;
      4: return 512; 5: return 768; default: return 1152;
    endcase
  endfunction

  function automatic int f_bpf(input int c, input int s);
    if (s == 1) return 32;
    if (s == 2) return (c <= 1) ? 128 : 256;
    return 64;
  endfunction

  function automatic int f_bclk(input int c, input int s, input int h);
    int q, hi;
    q  = 2 * f_ratio(c) / f_bpf(c, s);
    hi = ((s == 0 || s == 3) && (c == 1 || c == 6)) ? q / 3 : q / 2;
    return ((h % q) >= (q - hi)) ? 1 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Run frames, optionally changing config at frame 0 position chg_k.
  task automatic play(input int c0, input int s0, input int nfr, input int chg_k,
                      input int c1, input int s1, input bit via_slave);
    int cc, ss, r;
    if (via_slave) begin
      @(negedge mclk); master_en = 1'b0;
    end
    @(negedge mclk);
    ratio_code = 3'(c0); bpf_sel = 2'(s0); master_en = 1'b1;
    cc = c0; ss = s0;
    for (int f = 0; f < nfr; f++) begin
      r = f_ratio(cc);
      for (int k = 0; k < r; k++) begin
        @(posedge mclk); #5;
        chk($sformatf("R6/R7 bclk c%0d s%0d f%0d h%0d", cc, ss, f, 2*k),
            int'(bclk), f_bclk(cc, ss, 2*k));
        chk($sformatf("R3 lrclk c%0d s%0d f%0d k%0d", cc, ss, f, k),
            int'(lrclk), (k >= r/2) ? 1 : 0);
        @(negedge mclk); #5;
        chk($sformatf("R6/R7 bclk c%0d s%0d f%0d h%0d", cc, ss, f, 2*k+1),
            int'(bclk), f_bclk(cc, ss, 2*k+1));
        if (f == 0 && k == chg_k) begin
          ratio_code = 3'(c1); bpf_sel = 2'(s1);
        end
      end
      if (f == 0 && chg_k >= 0) begin
        cc = c1; ss = s1;  // R9: new setting from the next frame on
      end
      chk($sformatf("R1 clk_oe f%0d", f), int'(clk_oe), 1);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #35;
    // R1 reset state
    chk("R1 reset bclk", int'(bclk), 0);
    chk("R1 reset lrclk", int'(lrclk), 0);
    chk("R1 reset clk_oe", int'(clk_oe), 0);
    chk("R10 reset cfg_err", int'(cfg_err), 0);
    @(negedge mclk); rst_n = 1'b1;

    // R2 R4 R5 R6 R7: sweep of every legal ratio against every select
    for (int c = 0; c < 7; c++)
      for (int s = 0; s < 4; s++)
        play(c, s, 2, -1, c, s, 1'b1);

    // R9: mid-frame changes, including one in the last cycle
    play(2, 0, 2, 100, 0, 2, 1'b1);
    play(0, 1, 2, 127, 6, 0, 1'b1);
    play(3, 2, 2, 10, 5, 1, 1'b1);

    // R10: illegal code while running
    @(negedge mclk); #5;
    ratio_code = 3'd7; #1;
    chk("R10 cfg_err immediate", int'(cfg_err), 1);
    for (int i = 0; i < 6; i++) begin
      @(posedge mclk); #5;
      chk("R10 bclk stopped hi", int'(bclk), 0);
      chk("R10 lrclk stopped", int'(lrclk), 0);
      chk("R10 clk_oe kept", int'(clk_oe), 1);
      @(negedge mclk); #5;
      chk("R10 bclk stopped lo", int'(bclk), 0);
    end
    // R10 restart at a fresh frame when legal again (no slave detour)
    play(1, 0, 2, -1, 1, 0, 1'b0);

    // R1: slave mode quiets outputs; R10 flag low in slave
    @(negedge mclk); master_en = 1'b0; ratio_code = 3'd7; #1;
    chk("R10 cfg_err slave", int'(cfg_err), 0);
    for (int i = 0; i < 4; i++) begin
      @(posedge mclk); #5;
      chk("R1 slave bclk", int'(bclk), 0);
      chk("R1 slave lrclk", int'(lrclk), 0);
      chk("R1 slave clk_oe", int'(clk_oe), 0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule